// File: doc/BRIEF.md
# Serial Flash Command Engine

The block drives serial flash devices over a single-line SPI bus, one command per trigger. Software programs an opcode, a count of bytes to send after it, a count of bytes to receive, and a device select. The address, dummy and write bytes go into a shared byte buffer. Software then starts the command and polls a busy flag.

The engine pulls the selected chip select low. It shifts out the opcode, then the transmit bytes taken from the buffer, and then clocks in the receive bytes. Each received byte is written back into the same buffer, straight after the last byte that was sent. Software then reads the response from the buffer.

The buffer position the engine uses is an internal pointer. The pointer is not rewound when a command starts. Software rewinds it with a clear action.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After synchronous reset, all four chip selects are high, SCLK is low, and the bytes at 0x45, 0x48, 0x4B, 0x1D and 0x4F read 0.
- R2: The opcode byte (0x45), transmit count (0x48) and receive count (0x4B) read back the last value written. The buffer occupies bus addresses 0x80 to 0x80+BUF_DEPTH-1 and reads back what was written.
- R3: A command places exactly 8*(1+tx+rx) rising SCLK edges on the bus. MOSI carries the opcode first, then tx buffer bytes starting at the pointer, most significant bit first. The opcode is not part of the tx count.
- R4: Receive bytes, assembled MSB first from MISO sampled on SCLK rising edges, are stored in the buffer at the positions that directly follow the transmitted bytes.
- R5: Bit 7 of byte 0x4F (bit 31 of the status word at 0x4C) reads 1 from the cycle after an accepted trigger until the command ends, and 0 afterwards.
- R6: Writing 1 to bit 7 of byte 0x47 starts a command. The bit does not hold a value. A trigger written while busy has no effect: no extra SCLK edges, and the running opcode is unchanged.
- R7: The pointer is not rewound by a trigger. A command starts where the previous one stopped. Writing 1 to bit 4 of byte 0x02 (bit 20 of the control word at 0x00) while idle returns the pointer to buffer entry 0.
- R8: Byte 0x1D holds the device index in bits [1:0] and a select enable in bit 2. While a command runs, only spi_cs_n[index] is low when the enable is set, and none is low when it is clear. All chip selects are high whenever the engine is idle.
- R9: SCLK idles low (mode 0). Each SCLK high phase lasts CLK_DIV/2 clock cycles. MOSI does not change while SCLK is high.
- R10: Half duplex: receive clocking starts only after every transmit byte. MOSI is held at 1 for every receive bit.
- R11: The pointer wraps from entry BUF_DEPTH-1 to entry 0, for both transmit reads and receive writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register byte write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to devices |
| spi_miso | input | 1 | Serial data from devices |
| spi_cs_n | output | 4 | Active-low device selects |

## Verification
A wrong segment counter or pointer shows up directly on the pins and in the buffer. With a bad segment count, the number of SCLK rising edges differs from 8*(1+tx+rx) within one command. With a bad pointer, the second byte on MOSI, or the buffer entry read back after the command, holds the wrong value. Trouble with the busy or select state shows at once as chip selects low while idle, or as an extra transaction. The bench therefore compares whole MOSI byte streams, edge counts, the chip select at every edge and the buffer contents after each command.

// File: rtl/sfce_pkg.sv
package sfce_pkg;

    // Register byte offsets; software decodes these, so they are fixed.
    localparam logic [7:0] OFF_CTRL_B2 = 8'h02;  // byte 2 of control word
    localparam int         PCLR_BIT    = 4;      // pointer rewind action
    localparam logic [7:0] OFF_CSEL    = 8'h1D;
    localparam logic [7:0] OFF_OPC     = 8'h45;
    localparam logic [7:0] OFF_TRIG    = 8'h47;
    localparam int         TRIG_BIT    = 7;
    localparam logic [7:0] OFF_TXN     = 8'h48;
    localparam logic [7:0] OFF_RXN     = 8'h4B;
    localparam logic [7:0] OFF_STAT_B3 = 8'h4F;  // byte 3 of status word
    localparam logic [7:0] BUF_BASE    = 8'h80;

    localparam int NUM_CS = 4;

    typedef enum logic [1:0] {
        SEG_OPC,
        SEG_TX,
        SEG_RX
    } seg_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] txn;
        logic [7:0] rxn;
    } cmd_t;

    typedef struct packed {
        logic       en;
        logic [1:0] idx;
    } csel_t;

    // Active-low select vector for one command.
    function automatic logic [NUM_CS-1:0] cs_decode(input csel_t s);
        logic [NUM_CS-1:0] v;
        v = '1;
        for (int i = 0; i < NUM_CS; i++) begin
            if (s.en && (s.idx == 2'(i))) v[i] = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/sfce_regs.sv
module sfce_regs
    import sfce_pkg::*;
#(
    parameter  int BUF_DEPTH = 70,
    localparam int PTR_W     = $clog2(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             busy,
    output cmd_t             cmd,
    output csel_t            csel,
    output logic             trig_req,
    output logic             ptr_clr_req,
    input  logic [PTR_W-1:0] eng_ptr,
    output logic [7:0]       eng_rd_data,
    input  logic             eng_we,
    input  logic [7:0]       eng_wr_data
);

    logic [7:0]             opc_q;
    logic [7:0]             txn_q;
    logic [7:0]             rxn_q;
    csel_t                  csel_q;
    logic [7:0]             boff;
    logic                   in_buf;
    logic [PTR_W-1:0]       bidx;
    logic [BUF_DEPTH*8-1:0] flat;

    assign boff   = bus_addr - BUF_BASE;
    assign in_buf = bus_addr[7] && (boff < 8'(BUF_DEPTH));
    assign bidx   = boff[PTR_W-1:0];

    // Buffer entries: the engine's receive write wins over a bus write.
    for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_ent
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (eng_we && (eng_ptr == PTR_W'(g))) begin
                q <= eng_wr_data;
            end else if (bus_we && in_buf && (bidx == PTR_W'(g))) begin
                q <= bus_wdata;
            end
        end
        assign flat[g*8 +: 8] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q  <= '0;
            txn_q  <= '0;
            rxn_q  <= '0;
            csel_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFF_OPC:  opc_q  <= bus_wdata;
                OFF_TXN:  txn_q  <= bus_wdata;
                OFF_RXN:  rxn_q  <= bus_wdata;
                OFF_CSEL: csel_q <= bus_wdata[2:0];
                default:  ;
            endcase
        end
    end

    assign trig_req    = bus_we && (bus_addr == OFF_TRIG) && bus_wdata[TRIG_BIT];
    assign ptr_clr_req = bus_we && (bus_addr == OFF_CTRL_B2) && bus_wdata[PCLR_BIT];

    assign cmd  = '{opcode: opc_q, txn: txn_q, rxn: rxn_q};
    assign csel = csel_q;

    assign eng_rd_data = flat[eng_ptr*8 +: 8];

    always_comb begin
        bus_rdata = '0;
        if (in_buf) begin
            bus_rdata = flat[bidx*8 +: 8];
        end else begin
            case (bus_addr)
                OFF_OPC:     bus_rdata = opc_q;
                OFF_TXN:     bus_rdata = txn_q;
                OFF_RXN:     bus_rdata = rxn_q;
                OFF_CSEL:    bus_rdata = {5'b0, csel_q};
                OFF_STAT_B3: bus_rdata = {busy, 7'b0};
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sfce_shifter.sv
module sfce_shifter #(
    parameter  int CLK_DIV = 4,
    localparam int HALF    = CLK_DIV / 2,
    localparam int CNT_W   = $clog2(HALF) + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] din,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);

    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);

    logic             active;
    logic             phase;     // 0: SCLK low half, 1: SCLK high half
    logic [2:0]       bitn;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            phase  <= 1'b0;
            bitn   <= '0;
            cnt    <= '0;
            sh     <= 8'hFF;
            rx     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                phase  <= 1'b0;
                bitn   <= '0;
                cnt    <= '0;
                sh     <= din;
            end else if (active) begin
                if (cnt == HALF_LAST) begin
                    cnt <= '0;
                    if (!phase) begin
                        phase <= 1'b1;                // rising edge
                        rx    <= {rx[6:0], miso};
                    end else begin
                        phase <= 1'b0;                // falling edge
                        sh    <= {sh[6:0], 1'b1};
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign sclk = phase;
    assign mosi = sh[7];

endmodule

// File: rtl/sfce_seq.sv
module sfce_seq
    import sfce_pkg::*;
#(
    parameter  int BUF_DEPTH = 70,
    localparam int PTR_W     = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_req,
    input  logic              ptr_clr_req,
    input  cmd_t              cmd,
    input  csel_t             csel,
    output logic              busy,
    output logic [NUM_CS-1:0] cs_n,
    output logic [PTR_W-1:0]  ptr,
    output logic              eng_we,
    output logic [7:0]        eng_wr_data,
    input  logic [7:0]        eng_rd_data,
    output logic              sh_start,
    output logic [7:0]        sh_din,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx
);

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(BUF_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    seg_e       seg;
    logic [7:0] txleft;
    logic [7:0] rxleft;
    logic       accept;
    logic       fin_rx;
    logic [7:0] rx_after;

    assign accept   = trig_req && !busy;
    assign fin_rx   = busy && sh_done && (seg == SEG_RX);
    assign rx_after = fin_rx ? rxleft - 8'd1 : rxleft;

    assign eng_we      = fin_rx;
    assign eng_wr_data = sh_rx;

    always_comb begin
        sh_start = 1'b0;
        sh_din   = 8'hFF;
        if (accept) begin
            sh_start = 1'b1;
            sh_din   = cmd.opcode;
        end else if (busy && sh_done) begin
            if (txleft != 8'd0) begin
                sh_start = 1'b1;
                sh_din   = eng_rd_data;
            end else if (rx_after != 8'd0) begin
                sh_start = 1'b1;
                sh_din   = 8'hFF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cs_n   <= '1;
            ptr    <= '0;
            seg    <= SEG_OPC;
            txleft <= '0;
            rxleft <= '0;
        end else begin
            if (ptr_clr_req && !busy) begin
                ptr <= '0;
            end
            if (accept) begin
                busy   <= 1'b1;
                cs_n   <= cs_decode(csel);
                txleft <= cmd.txn;
                rxleft <= cmd.rxn;
                seg    <= SEG_OPC;
            end else if (busy && sh_done) begin
                if (fin_rx) begin
                    rxleft <= rx_after;
                    ptr    <= ptr_inc(ptr);
                end
                if (txleft != 8'd0) begin
                    seg    <= SEG_TX;
                    txleft <= txleft - 8'd1;
                    ptr    <= ptr_inc(ptr);
                end else if (rx_after != 8'd0) begin
                    seg <= SEG_RX;
                end else begin
                    busy <= 1'b0;
                    cs_n <= '1;
                end
            end
        end
    end

endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
    import sfce_pkg::*;
#(
    parameter int BUF_DEPTH = 70,
    parameter int CLK_DIV   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic [3:0]  spi_cs_n
);

    localparam int PTR_W = $clog2(BUF_DEPTH);

    cmd_t             cmd;
    csel_t            csel;
    logic             busy;
    logic             trig_req;
    logic             ptr_clr_req;
    logic [PTR_W-1:0] ptr;
    logic             eng_we;
    logic [7:0]       eng_wr_data;
    logic [7:0]       eng_rd_data;
    logic             sh_start;
    logic [7:0]       sh_din;
    logic             sh_done;
    logic [7:0]       sh_rx;

    sfce_regs #(.BUF_DEPTH(BUF_DEPTH)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .busy        (busy),
        .cmd         (cmd),
        .csel        (csel),
        .trig_req    (trig_req),
        .ptr_clr_req (ptr_clr_req),
        .eng_ptr     (ptr),
        .eng_rd_data (eng_rd_data),
        .eng_we      (eng_we),
        .eng_wr_data (eng_wr_data)
    );

    sfce_seq #(.BUF_DEPTH(BUF_DEPTH)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .trig_req    (trig_req),
        .ptr_clr_req (ptr_clr_req),
        .cmd         (cmd),
        .csel        (csel),
        .busy        (busy),
        .cs_n        (spi_cs_n),
        .ptr         (ptr),
        .eng_we      (eng_we),
        .eng_wr_data (eng_wr_data),
        .eng_rd_data (eng_rd_data),
        .sh_start    (sh_start),
        .sh_din      (sh_din),
        .sh_done     (sh_done),
        .sh_rx       (sh_rx)
    );

    sfce_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .din   (sh_din),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

endmodule

// File: rtl/sfce_checker.sv
module sfce_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_we,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       spi_sclk,
    input logic       spi_mosi,
    input logic [3:0] spi_cs_n,
    input logic       busy
);

    // R8: never more than one device selected
    assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n));

    // R8: idle engine selects nothing
    assert_cs_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_cs_n == 4'hF));

    // R9: serial clock rests low outside a command
    assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_sclk);

    // R9: data line steady during the high phase
    assert_mosi_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R5: an accepted trigger raises busy on the next cycle
    assert_trigger_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h47 && bus_wdata[7] && !busy) |=> busy);

endmodule

bind sflash_cmd_engine sfce_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n),
    .busy      (busy)
);

// File: tb/sim_sflash_cmd_engine.sv
`timescale 1ns/1ps
module sim_sflash_cmd_engine;

    localparam int HALF = 2;   // default CLK_DIV / 2
    localparam int CAPN = 8192;

    // {opcode, tx count, rx count, select byte}
    localparam logic [31:0] VEC [6] = '{
        {8'h03, 8'd3, 8'd4, 8'h04},
        {8'h0B, 8'd4, 8'd8, 8'h05},
        {8'h9F, 8'd0, 8'd3, 8'h06},
        {8'h02, 8'd5, 8'd0, 8'h07},
        {8'h05, 8'd1, 8'd2, 8'h00},
        {8'h06, 8'd0, 8'd0, 8'h03}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso;
    logic [3:0] spi_cs_n;

    int total = 0;
    int bad = 0;
    int slv_bit = 0;
    int slv_base = 0;
    int hi_cnt = 0;
    logic       cap [CAPN];
    logic [3:0] csl [CAPN];

    always #10 clk = ~clk;

    sflash_cmd_engine u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    function automatic logic [7:0] resp(input int n);
        return 8'(n * 53 + 17) ^ 8'h5A;
    endfunction

    function automatic logic resp_bit(input int b);
        logic [7:0] r;
        r = resp(b / 8);
        return r[7 - (b % 8)];
    endfunction

    // Device model: presents bits MSB first, captures MOSI and selects on rising SCLK.
    assign spi_miso = resp_bit(slv_bit - slv_base);

    always @(posedge spi_sclk) begin
        cap[slv_bit % CAPN] = spi_mosi;
        csl[slv_bit % CAPN] = spi_cs_n;
        slv_bit = slv_bit + 1;
    end

    always @(posedge clk) if (spi_sclk) hi_cnt = hi_cnt + 1;

    function automatic logic [7:0] cap_byte(input int base, input int n);
        logic [7:0] v;
        for (int j = 0; j < 8; j++) v[7 - j] = cap[(base + n * 8 + j) % CAPN];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(8'h4F, s);
            if (!s[7]) break;
        end
    endtask

    // Program and start one command; returns the device-side bit index where it began.
    task automatic start_cmd(input logic [7:0] op, input int tx, input int rx,
                             input logic [7:0] csb, output int base, output int hib);
        wr(8'h45, op);
        wr(8'h48, 8'(tx));
        wr(8'h4B, 8'(rx));
        wr(8'h1D, csb);
        @(negedge clk);
        slv_base = slv_bit;
        base = slv_bit;
        hib = hi_cnt;
        wr(8'h47, 8'h80);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int base;
        int hib;
        int rises;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(spi_cs_n == 4'hF, "R1 cs_n", spi_cs_n, 4'hF);
        chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
        rd(8'h4F, d); chk(d == 8'h00, "R1 status", d, 0);
        rd(8'h45, d); chk(d == 8'h00, "R1 opcode", d, 0);
        rd(8'h48, d); chk(d == 8'h00, "R1 txcount", d, 0);
        rd(8'h4B, d); chk(d == 8'h00, "R1 rxcount", d, 0);
        rd(8'h1D, d); chk(d == 8'h00, "R1 select", d, 0);

        // R2: readback
        wr(8'h45, 8'hA5); rd(8'h45, d); chk(d == 8'hA5, "R2 opcode", d, 8'hA5);
        wr(8'h48, 8'h3C); rd(8'h48, d); chk(d == 8'h3C, "R2 txcount", d, 8'h3C);
        wr(8'h4B, 8'hC3); rd(8'h4B, d); chk(d == 8'hC3, "R2 rxcount", d, 8'hC3);
        wr(8'h80 + 8'd69, 8'h96); rd(8'h80 + 8'd69, d); chk(d == 8'h96, "R2 buffer", d, 8'h96);

        // Table walk: R3, R4, R8, R9, R10
        for (int k = 0; k < 6; k++) begin
            logic [7:0] op, csb;
            int tx, rx;
            logic [3:0] ecs;
            bit ok;
            op = VEC[k][31:24]; tx = int'(VEC[k][23:16]);
            rx = int'(VEC[k][15:8]); csb = VEC[k][7:0];
            ecs = csb[2] ? ~(4'b0001 << csb[1:0]) : 4'hF;
            wr(8'h02, 8'h10);
            for (int i = 0; i < tx; i++) wr(8'h80 + 8'(i), 8'(k * 29 + i * 13 + 7));
            start_cmd(op, tx, rx, csb, base, hib);
            wait_idle();
            rises = slv_bit - base;
            chk(rises == 8 * (1 + tx + rx), "R3 edge count", rises, 8 * (1 + tx + rx));
            chk(cap_byte(base, 0) == op, "R3 opcode first", cap_byte(base, 0), op);
            ok = 1'b1;
            for (int i = 0; i < tx; i++)
                if (cap_byte(base, 1 + i) != 8'(k * 29 + i * 13 + 7)) ok = 1'b0;
            chk(ok, "R3 tx bytes", k, 1);
            ok = 1'b1;
            for (int i = 0; i < rx; i++)
                if (cap_byte(base, 1 + tx + i) != 8'hFF) ok = 1'b0;
            chk(ok, "R10 mosi high in rx", k, 1);
            ok = 1'b1;
            for (int i = 0; i < rx; i++) begin
                rd(8'h80 + 8'(tx + i), d);
                if (d != resp(1 + tx + i)) ok = 1'b0;
            end
            chk(ok, "R4 rx placement", k, 1);
            ok = 1'b1;
            for (int i = 0; i < rises; i++)
                if (csl[(base + i) % CAPN] != ecs) ok = 1'b0;
            chk(ok, "R8 select during command", k, ecs);
            chk(spi_cs_n == 4'hF, "R8 select after command", spi_cs_n, 4'hF);
            chk(hi_cnt - hib == rises * HALF, "R9 high phase length", hi_cnt - hib, rises * HALF);
        end

        // R5, R6: busy flag and trigger while busy
        wr(8'h02, 8'h10);
        wr(8'h80, 8'h11); wr(8'h81, 8'h22); wr(8'h83, 8'h33);
        start_cmd(8'h3B, 2, 1, 8'h04, base, hib);
        rd(8'h4F, d); chk(d[7] == 1'b1, "R5 busy while running", d, 8'h80);
        rd(8'h47, d); chk(d == 8'h00, "R6 trigger self-clears", d, 0);
        wr(8'h45, 8'hEE);
        wr(8'h47, 8'h80);
        wait_idle();
        rd(8'h4F, d); chk(d[7] == 1'b0, "R5 busy clears", d, 0);
        rises = slv_bit - base;
        chk(rises == 32, "R6 retrigger ignored edges", rises, 32);
        chk(cap_byte(base, 0) == 8'h3B, "R6 opcode kept", cap_byte(base, 0), 8'h3B);
        repeat (100) @(negedge clk);
        chk(slv_bit - base == 32, "R6 no second command", slv_bit - base, 32);
        rd(8'h82, d); chk(d == resp(3), "R4 rx after tx", d, resp(3));

        // R7: pointer continues, then rewinds
        start_cmd(8'h3B, 1, 1, 8'h04, base, hib);
        wait_idle();
        chk(cap_byte(base, 1) == 8'h33, "R7 continues at pointer", cap_byte(base, 1), 8'h33);
        rd(8'h84, d); chk(d == resp(2), "R7 rx after continued tx", d, resp(2));
        wr(8'h02, 8'h10);
        start_cmd(8'h3B, 1, 0, 8'h04, base, hib);
        wait_idle();
        chk(cap_byte(base, 1) == 8'h11, "R7 rewound to entry 0", cap_byte(base, 1), 8'h11);

        // R11: wrap of the pointer
        for (int i = 0; i < 70; i++) wr(8'h80 + 8'(i), 8'(i * 3 + 1));
        wr(8'h02, 8'h10);
        start_cmd(8'h0B, 60, 8, 8'h05, base, hib);
        wait_idle();
        rd(8'h80 + 8'd67, d); chk(d == resp(68), "R11 last rx before wrap", d, resp(68));
        start_cmd(8'h0B, 4, 1, 8'h05, base, hib);
        wait_idle();
        chk(cap_byte(base, 1) == 8'(68 * 3 + 1), "R11 tx entry 68", cap_byte(base, 1), 8'(68 * 3 + 1));
        chk(cap_byte(base, 3) == 8'h01, "R11 tx wraps to entry 0", cap_byte(base, 3), 8'h01);
        chk(cap_byte(base, 4) == 8'h04, "R11 tx entry 1", cap_byte(base, 4), 8'h04);
        rd(8'h82, d); chk(d == resp(5), "R11 rx after wrap", d, resp(5));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule